// File: doc/BRIEF.md
# Spread Spectrum Modulation Profile Generator

This block drives the feedback divide word of a fractional-N frequency synthesizer loop. While it runs, it sweeps that word along a linear triangle, so the synthesized clock is frequency-modulated and its energy is spread over a band. The word is unsigned fixed point, with 10 integer bits and 16 fractional bits. A one-cycle strobe marks the first cycle of every modulation period.

There are two geometries. In center mode the triangle is symmetric about the nominal word, so the long-run average equals nominal. In down mode the nominal word is the ceiling, and the whole excursion lies below it. A 4-bit amount code sets the depth of the sweep, and a rate select picks one of two period lengths counted in reference cycles. The mode, amount, rate and nominal value are sampled only when a period begins. The loop therefore never sees a profile that is half one setting and half another.

Top module: `sscg_profile_gen`

## Requirements
- R1: While `en` is low, `word_o` equals `nom_i`, follows it combinationally, and `strobe_o` stays low.
- R2: After `en` rises, the first clock edge starts a period. `strobe_o` is high for exactly one cycle at the start of each period. A period lasts `PERIOD_SLOW` cycles when `fast_i`=0 and `PERIOD_FAST` cycles when `fast_i`=1.
- R3: Center mode (`mode_i`=0) uses the deviation A = floor(nom·(code+1)/800) in word units, which is 0.125% steps from 0.125% at code 0 to 2.0% at code 15. The word ranges from nom−A to nom+A, and the sum over one period equals period·nom.
- R4: Down mode (`mode_i`=1) uses the deviation A = floor(nom·(code+1)/400), which is 0.25% steps from 0.25% to 4.0%. The maximum word equals nom, the minimum is nom−A, and the period average is below nom.
- R5: Period index k counts from 0 at the strobe. With L = period/4 (center) or period/2 (down) and j = k mod 2L, the deviation magnitude is floor(j·A/L) for j≤L and A−floor((j−L)·A/L) for j>L. In down mode it is subtracted. In center mode it is added for k<2L and subtracted after that. Every period starts at nom.
- R6: The extreme is reached exactly at j = L, with magnitude A and no rounding residue.
- R7: Additions saturate at the all-ones word (2^26−1) and subtractions saturate at zero. The word never wraps.
- R8: A change to `mode_i`, `amount_i`, `fast_i` or `nom_i` during a running period leaves that period unchanged and takes effect from the next strobe.
- R9: While `rst` is high, `strobe_o` is low and `word_o` equals `nom_i`, whatever the level of `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulation enable |
| nom_i | input | 26 | Nominal divide word, 10.16 unsigned |
| mode_i | input | 1 | 0 = center spread, 1 = down spread |
| amount_i | input | 4 | Spread amount code |
| fast_i | input | 1 | 0 = slow period, 1 = fast period |
| word_o | output | 26 | Instantaneous divide word, 10.16 unsigned |
| strobe_o | output | 1 | One-cycle pulse on the first cycle of each period |

## Verification
The hardest case to reach from the ports is a nominal word close to full scale combined with the largest center code. The upper half of the triangle must then clamp at all ones, and the lower half must still follow the exact ramp. The stimulus table holds one vector with `nom_i` set to all ones and code 15, and every cycle of that period is compared against the closed-form profile with clamping. A second hard case is a configuration change that arrives mid-period. A directed test flips every setting halfway through a period, checks that the rest of that period follows the old profile, and then checks the next period against the new settings.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

    localparam int INT_W      = 10;
    localparam int FRAC_W     = 16;
    localparam int WORD_W     = INT_W + FRAC_W;
    localparam int CODE_W     = 4;
    localparam int AMP_W      = 24;
    localparam int PROD_W     = WORD_W + CODE_W + 1;
    localparam int CENTER_DIV = 800;   // 0.125 % steps of half-deviation
    localparam int DOWN_DIV   = 400;   // 0.25 % steps of full deviation

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [AMP_W-1:0]  amp_t;

    typedef enum logic {
        SPREAD_CENTER = 1'b0,
        SPREAD_DOWN   = 1'b1
    } spread_e;

    typedef struct packed {
        spread_e             mode;
        logic [CODE_W-1:0]   amount;
        logic                fast;
        word_t               nom;
    } prof_cfg_t;

    localparam word_t WORD_MAX = '1;

    // Peak deviation in word units for a given mode and amount code.
    function automatic amp_t calc_amp(spread_e mode, logic [CODE_W-1:0] amount, word_t nom);
        logic [PROD_W-1:0] prod;
        prod = PROD_W'(nom) * PROD_W'({1'b0, amount} + 5'd1);
        if (mode == SPREAD_DOWN)
            return amp_t'(prod / PROD_W'(DOWN_DIV));
        else
            return amp_t'(prod / PROD_W'(CENTER_DIV));
    endfunction

    function automatic word_t sat_add(word_t base, amp_t m);
        logic [WORD_W:0] s;
        s = {1'b0, base} + (WORD_W+1)'(m);
        return s[WORD_W] ? WORD_MAX : s[WORD_W-1:0];
    endfunction

    function automatic word_t sat_sub(word_t base, amp_t m);
        logic [WORD_W:0] d;
        d = {1'b0, base} - (WORD_W+1)'(m);
        return d[WORD_W] ? '0 : d[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/sscg_cfg_latch.sv
module sscg_cfg_latch
    import sscg_pkg::*;
#(
    parameter int PERIOD_SLOW = 800,
    parameter int PERIOD_FAST = 208,
    parameter int CNT_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  prof_cfg_t         cfg_in,
    output spread_e           mode_q,
    output word_t             nom_q,
    output amp_t              amp_q,
    output amp_t              step_q,
    output logic [CNT_W-1:0]  rem_q,
    output logic [CNT_W-1:0]  len_q,
    output logic [CNT_W-1:0]  per_q
);

    localparam int LEN_CS = PERIOD_SLOW / 4;
    localparam int LEN_CF = PERIOD_FAST / 4;
    localparam int LEN_DS = PERIOD_SLOW / 2;
    localparam int LEN_DF = PERIOD_FAST / 2;

    amp_t             amp_c, step_c;
    logic [CNT_W-1:0] rem_c, len_c, per_c;

    // Divisors are constants per {mode, rate}, so each branch is a fixed divide.
    always_comb begin
        amp_c = calc_amp(cfg_in.mode, cfg_in.amount, cfg_in.nom);
        per_c = cfg_in.fast ? CNT_W'(PERIOD_FAST) : CNT_W'(PERIOD_SLOW);
        case ({cfg_in.mode == SPREAD_DOWN, cfg_in.fast})
            2'b00: begin
                len_c  = CNT_W'(LEN_CS);
                step_c = amp_c / amp_t'(LEN_CS);
                rem_c  = CNT_W'(amp_c % amp_t'(LEN_CS));
            end
            2'b01: begin
                len_c  = CNT_W'(LEN_CF);
                step_c = amp_c / amp_t'(LEN_CF);
                rem_c  = CNT_W'(amp_c % amp_t'(LEN_CF));
            end
            2'b10: begin
                len_c  = CNT_W'(LEN_DS);
                step_c = amp_c / amp_t'(LEN_DS);
                rem_c  = CNT_W'(amp_c % amp_t'(LEN_DS));
            end
            default: begin
                len_c  = CNT_W'(LEN_DF);
                step_c = amp_c / amp_t'(LEN_DF);
                rem_c  = CNT_W'(amp_c % amp_t'(LEN_DF));
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SPREAD_CENTER;
            nom_q  <= '0;
            amp_q  <= '0;
            step_q <= '0;
            rem_q  <= '0;
            len_q  <= CNT_W'(LEN_CS);
            per_q  <= CNT_W'(PERIOD_SLOW);
        end else if (load) begin
            mode_q <= cfg_in.mode;
            nom_q  <= cfg_in.nom;
            amp_q  <= amp_c;
            step_q <= step_c;
            rem_q  <= rem_c;
            len_q  <= len_c;
            per_q  <= per_c;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(nom_q) && $stable(mode_q) && $stable(per_q))); // R8

endmodule

// File: rtl/sscg_tri_ramp.sv
module sscg_tri_ramp
    import sscg_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  spread_e           mode,
    input  amp_t              amp,
    input  amp_t              step,
    input  logic [CNT_W-1:0]  rem,
    input  logic [CNT_W-1:0]  len,
    input  logic [CNT_W-1:0]  per,
    output logic              load,
    output logic              run,
    output logic              strobe,
    output logic              neg,
    output amp_t              mag
);

    logic             run_q, lobe_q;
    logic [CNT_W-1:0] cnt_q, lpos_q, err_q, err_nx;
    logic [CNT_W:0]   err_sum;
    amp_t             mag_q, delta;
    logic             carry, rising, lobe_end;

    assign load     = en && (!run_q || (cnt_q == per - 1'b1));
    assign err_sum  = {1'b0, err_q} + {1'b0, rem};
    assign carry    = err_sum >= {1'b0, len};
    assign err_nx   = carry ? CNT_W'(err_sum - {1'b0, len}) : CNT_W'(err_sum);
    assign delta    = step + amp_t'(carry);
    assign rising   = lpos_q < len;
    assign lobe_end = ({1'b0, lpos_q} == ({len, 1'b0} - 1'b1));

    // Error-accumulated ramp: after L steps the magnitude lands exactly on amp.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            lpos_q <= '0;
            lobe_q <= 1'b0;
            mag_q  <= '0;
            err_q  <= '0;
        end else if (load) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            lpos_q <= '0;
            lobe_q <= 1'b0;
            mag_q  <= '0;
            err_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            err_q  <= err_nx;
            mag_q  <= rising ? mag_q + delta : mag_q - delta;
            if (lobe_end) begin
                lpos_q <= '0;
                lobe_q <= ~lobe_q;
            end else begin
                lpos_q <= lpos_q + 1'b1;
            end
        end
    end

    assign run    = run_q;
    assign strobe = run_q && (cnt_q == '0);
    assign neg    = run_q && ((mode == SPREAD_DOWN) || lobe_q);
    assign mag    = mag_q;

    AST_MAG_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (mag_q <= amp)); // R6
    AST_PEAK_EXACT: assert property (@(posedge clk) disable iff (rst)
        (run_q && lpos_q == len) |-> (mag_q == amp)); // R6
    AST_LOBE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (run_q && lpos_q == '0) |-> (mag_q == '0)); // R5
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe); // R2

endmodule

// File: rtl/sscg_profile_gen.sv
module sscg_profile_gen
    import sscg_pkg::*;
#(
    parameter int PERIOD_SLOW = 800,
    parameter int PERIOD_FAST = 208
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [WORD_W-1:0]    nom_i,
    input  logic                 mode_i,
    input  logic [CODE_W-1:0]    amount_i,
    input  logic                 fast_i,
    output logic [WORD_W-1:0]    word_o,
    output logic                 strobe_o
);

    localparam int PMAX  = (PERIOD_SLOW > PERIOD_FAST) ? PERIOD_SLOW : PERIOD_FAST;
    localparam int CNT_W = $clog2(PMAX + 1);

    prof_cfg_t        cfg_in;
    spread_e          mode_q;
    word_t            nom_q;
    amp_t             amp_q, step_q, mag;
    logic [CNT_W-1:0] rem_q, len_q, per_q;
    logic             load, run, neg;

    assign cfg_in = '{mode: spread_e'(mode_i), amount: amount_i, fast: fast_i, nom: nom_i};

    sscg_cfg_latch #(
        .PERIOD_SLOW (PERIOD_SLOW),
        .PERIOD_FAST (PERIOD_FAST),
        .CNT_W       (CNT_W)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (cfg_in),
        .mode_q (mode_q),
        .nom_q  (nom_q),
        .amp_q  (amp_q),
        .step_q (step_q),
        .rem_q  (rem_q),
        .len_q  (len_q),
        .per_q  (per_q)
    );

    sscg_tri_ramp #(
        .CNT_W (CNT_W)
    ) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .mode   (mode_q),
        .amp    (amp_q),
        .step   (step_q),
        .rem    (rem_q),
        .len    (len_q),
        .per    (per_q),
        .load   (load),
        .run    (run),
        .strobe (strobe_o),
        .neg    (neg),
        .mag    (mag)
    );

    always_comb begin
        if (!run)
            word_o = nom_i;
        else if (neg)
            word_o = sat_sub(nom_q, mag);
        else
            word_o = sat_add(nom_q, mag);
    end

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !en |=> !strobe_o); // R1
    AST_DOWN_CEILING: assert property (@(posedge clk) disable iff (rst)
        (run && mode_q == SPREAD_DOWN) |-> (word_o <= nom_q)); // R4
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && !neg) |-> (word_o >= nom_q)); // R7
    AST_START_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> (word_o == nom_q)); // R5

endmodule

// File: tb/sscg_profile_gen_test.sv
module sscg_profile_gen_test;
    import sscg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PS = 800;
    localparam int PF = 208;
    localparam longint WMAX = 64'd67108863;

    logic        clk = 1'b0;
    logic        rst, en, mode_i, fast_i, strobe_o;
    logic [3:0]  amount_i;
    logic [25:0] nom_i, word_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sscg_profile_gen #(.PERIOD_SLOW(PS), .PERIOD_FAST(PF)) uut (
        .clk(clk), .rst(rst), .en(en), .nom_i(nom_i), .mode_i(mode_i),
        .amount_i(amount_i), .fast_i(fast_i), .word_o(word_o), .strobe_o(strobe_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Closed-form profile taken from the requirements (R3..R7).
    function automatic longint exp_word(bit md, int code, bit fst, longint nom, int k);
        int P, L, j, lobe;
        longint A, m, v;
        P = fst ? PF : PS;
        A = md ? (nom * (code + 1)) / 400 : (nom * (code + 1)) / 800;
        L = md ? P / 2 : P / 4;
        lobe = k / (2 * L);
        j = k % (2 * L);
        m = (j <= L) ? (j * A) / L : A - ((j - L) * A) / L;
        v = (md || lobe == 1) ? nom - m : nom + m;
        if (v > WMAX) v = WMAX;
        if (v < 0) v = 0;
        return v;
    endfunction

    typedef struct packed {
        bit        md;
        bit [3:0]  code;
        bit        fst;
        bit [25:0] nom;
        bit [25:0] emin;
        bit [25:0] emax;
        bit        exact_avg;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 4'd7,  1'b0, 26'd6553600,  26'd6488064,  26'd6619136,  1'b1},
        '{1'b1, 4'd3,  1'b1, 26'd6553600,  26'd6488064,  26'd6553600,  1'b0},
        '{1'b0, 4'd0,  1'b1, 26'd65536,    26'd65455,    26'd65617,    1'b1},
        '{1'b1, 4'd15, 1'b0, 26'd65536,    26'd62915,    26'd65536,    1'b0},
        '{1'b0, 4'd15, 1'b1, 26'd67108863, 26'd65766686, 26'd67108863, 1'b0}
    };

    // Called at the negedge of period cycle 0; returns at cycle 0 of the next period.
    task automatic observe(input bit md, input int code, input bit fst, input longint nom,
                           input int chg_at, input string req,
                           output longint mn, output longint mx, output longint sum);
        int P, wbad, sbad;
        longint wa, we;
        P = fst ? PF : PS;
        wbad = 0; sbad = 0; wa = 0; we = 0;
        mn = WMAX + 1; mx = -1; sum = 0;
        for (int k = 0; k < P; k++) begin
            longint e;
            e = exp_word(md, code, fst, nom, k);
            if (longint'(word_o) != e) begin
                if (wbad == 0) begin wa = longint'(word_o); we = e; end
                wbad++;
            end
            if (strobe_o !== (k == 0)) sbad++;
            if (longint'(word_o) < mn) mn = longint'(word_o);
            if (longint'(word_o) > mx) mx = longint'(word_o);
            sum += longint'(word_o);
            if (k == chg_at) begin
                mode_i   = ~md;
                amount_i = ~code[3:0];
                fast_i   = ~fst;
                nom_i    = nom_i ^ 26'h155;
            end
            @(negedge clk);
        end
        check(wbad == 0, req, "per-cycle profile word", wa, we);
        check(sbad == 0, "R2", "strobe only on cycle 0", sbad, 0);
        check(strobe_o === 1'b1, "R2", "strobe after full period", strobe_o, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        longint mn, mx, sum;
        rst = 1'b1; en = 1'b0; mode_i = 1'b0; amount_i = 4'd0; fast_i = 1'b0;
        nom_i = 26'd6553600;
        repeat (3) @(negedge clk);
        check(strobe_o === 1'b0, "R9", "strobe in reset", strobe_o, 0);
        check(word_o == nom_i, "R9", "word in reset", word_o, nom_i);
        en = 1'b1;
        @(negedge clk);
        check(strobe_o === 1'b0, "R9", "strobe in reset with enable", strobe_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(strobe_o === 1'b1, "R2", "first strobe after reset release", strobe_o, 1);

        // Vector table walk.
        for (int i = 0; i < 5; i++) begin
            string rq;
            en = 1'b0;
            mode_i = VECS[i].md; amount_i = VECS[i].code; fast_i = VECS[i].fst;
            nom_i = VECS[i].nom;
            @(negedge clk);
            en = 1'b1;
            @(negedge clk);
            rq = VECS[i].md ? "R4" : "R3";
            observe(VECS[i].md, int'(VECS[i].code), VECS[i].fst, longint'(VECS[i].nom),
                    -1, "R5", mn, mx, sum);
            check(mn == longint'(VECS[i].emin), "R6", "period minimum", mn, VECS[i].emin);
            check(mx == longint'(VECS[i].emax), i == 4 ? "R7" : rq, "period maximum",
                  mx, VECS[i].emax);
            if (VECS[i].exact_avg)
                check(sum == longint'(VECS[i].nom) * (VECS[i].fst ? PF : PS), "R3",
                      "center period sum", sum, longint'(VECS[i].nom) * (VECS[i].fst ? PF : PS));
            if (VECS[i].md)
                check(sum < longint'(VECS[i].nom) * (VECS[i].fst ? PF : PS), "R4",
                      "down average below nominal", sum,
                      longint'(VECS[i].nom) * (VECS[i].fst ? PF : PS));
        end

        // R8: settings flipped halfway through a period.
        en = 1'b0;
        mode_i = 1'b0; amount_i = 4'd7; fast_i = 1'b0; nom_i = 26'd6553600;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        observe(1'b0, 7, 1'b0, 64'd6553600, PS / 2, "R8", mn, mx, sum);
        observe(1'b1, 8, 1'b1, longint'(26'd6553600 ^ 26'h155), -1, "R8", mn, mx, sum);

        // R1: disabled output tracks nominal, no strobe.
        en = 1'b0;
        @(negedge clk);
        check(strobe_o === 1'b0, "R1", "no strobe when disabled", strobe_o, 0);
        check(word_o == nom_i, "R1", "word equals nominal when disabled", word_o, nom_i);
        nom_i = 26'd123456;
        #1;
        check(word_o == 26'd123456, "R1", "word follows nominal input", word_o, 123456);
        begin
            int seen;
            seen = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (strobe_o !== 1'b0 || word_o != 26'd123456) seen++;
            end
            check(seen == 0, "R1", "idle cycles without strobe or deviation", seen, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule